// File: doc/BRIEF.md
# Byte-Addressed Load/Store Alignment Unit

This unit sits between a 32-bit register datapath and a data memory that is one word wide and has one write enable per byte. It receives an already computed byte address, an access size, a load/store flag, the register value to be stored and a signedness flag for loads. On a store it produces the word address, the byte-lane enables and write data with the source value copied into every lane the access might use. On a load it takes the word returned by memory, picks out the addressed byte or halfword and widens it to 32 bits with sign or zero fill.

Bytes are numbered big-endian inside a word: byte offset 0 is bits 31:24 and offset 3 is bits 7:0. A halfword access must sit on an even address and a word access on a multiple of four. Any other access raises a misalignment flag, and no lane is written. All outputs are registered, so results appear one clock after the inputs are presented. An active-low asynchronous reset clears every output.

Size codes on `acc_size_i` are 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 word.

Top module: `lsa_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: One cycle after any access, `word_addr_o` equals bits 31:2 of the address presented.
- R3: A byte store enables only the addressed lane (offset 0 is `byte_en_o[3]`, offset 3 is `byte_en_o[0]`), and `wdata_o` holds bits 7:0 of the source in all four lanes.
- R4: An aligned halfword store at offset 0 enables 4'b1100 and at offset 2 enables 4'b0011, and `wdata_o` holds bits 15:0 of the source in both halves.
- R5: An aligned word store enables 4'b1111 and passes the source unchanged to `wdata_o`.
- R6: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, sets `misalign_o`, drives `byte_en_o` to 0 and drives `ld_data_o` to 0. Aligned accesses and all byte accesses clear `misalign_o`.
- R7: A load never drives any byte enable.
- R8: A signed byte or halfword load returns the selected big-endian lane sign-extended to 32 bits. A halfword at offset 0 comes from bits 31:16 and a halfword at offset 2 comes from bits 15:0.
- R9: An unsigned byte or halfword load returns the selected lane zero-extended to 32 bits.
- R10: An aligned word load returns the memory word unchanged, whatever the signedness flag.
- R11: Size code 2'b11 behaves exactly as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Byte address of the access |
| acc_size_i | input | 2 | Access size code |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| ld_signed_i | input | 1 | 1 selects sign extension on sub-word loads |
| st_data_i | input | 32 | Register value to store |
| mem_rdata_i | input | 32 | Word read from memory |
| word_addr_o | output | 30 | Word address to memory |
| byte_en_o | output | 4 | Per-lane write enables, bit 3 is offset 0 |
| wdata_o | output | 32 | Lane-replicated write data |
| ld_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Access not naturally aligned |

## Verification
The bench goes through every offset with every size code, for loads and stores, using data whose top bit of each lane is set and cleared in turn. If the lane numbering were reversed, the wrong byte would be enabled or returned at offsets 0 and 3. If the extension were mixed up, a signed load of 0x80 would come back as 0x00000080 rather than 0xFFFFFF80. Misaligned halfword and word accesses are checked for a write that gets through. Size code 2'b11 is checked for a fall into the byte or halfword path.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE     = 2'b00,
        ACC_HALF     = 2'b01,
        ACC_WORD     = 2'b10,
        ACC_WORD_ALT = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check #(
    parameter int OFF_W = 2
) (
    input  lsa_pkg::acc_size_e  size_i,
    input  logic [OFF_W-1:0]    off_i,
    output logic                misalign_o
);
    import lsa_pkg::*;

    always_comb begin
        unique case (size_i)
            ACC_BYTE:               misalign_o = 1'b0;
            ACC_HALF:               misalign_o = off_i[0];
            ACC_WORD, ACC_WORD_ALT: misalign_o = |off_i;
            default:                misalign_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes #(
    parameter int XLEN = 32
) (
    input  lsa_pkg::acc_size_e         size_i,
    input  logic [$clog2(XLEN/8)-1:0]  off_i,
    input  logic                       store_i,
    input  logic                       misalign_i,
    input  logic [XLEN-1:0]            src_i,
    output logic [XLEN/8-1:0]          en_o,
    output logic [XLEN-1:0]            data_o
);
    import lsa_pkg::*;
    localparam int NLANE = XLEN / 8;
    localparam int OFF_W = $clog2(NLANE);

    // big-endian: offset k drives lane index NLANE-1-k
    logic [OFF_W-1:0] lane_sel;
    assign lane_sel = ~off_i;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic hit;
        always_comb begin
            unique case (size_i)
                ACC_BYTE: hit = (lane_sel == OFF_W'(g));
                ACC_HALF: hit = (lane_sel[OFF_W-1:1] == g[OFF_W-1:1]);
                default:  hit = 1'b1;
            endcase
        end
        assign en_o[g] = store_i & ~misalign_i & hit;
    end

    always_comb begin
        unique case (size_i)
            ACC_BYTE: data_o = {NLANE{src_i[7:0]}};
            ACC_HALF: data_o = {(NLANE/2){src_i[15:0]}};
            default:  data_o = src_i;
        endcase
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract #(
    parameter int XLEN = 32
) (
    input  lsa_pkg::acc_size_e         size_i,
    input  logic [$clog2(XLEN/8)-1:0]  off_i,
    input  logic                       signed_i,
    input  logic                       misalign_i,
    input  logic [XLEN-1:0]            word_i,
    output logic [XLEN-1:0]            data_o
);
    import lsa_pkg::*;
    localparam int NLANE = XLEN / 8;
    localparam int OFF_W = $clog2(NLANE);

    logic [OFF_W-1:0] byte_idx;
    logic [7:0]       sel_b;
    logic [15:0]      sel_h;

    assign byte_idx = ~off_i;
    assign sel_b    = word_i[{byte_idx, 3'b000} +: 8];
    assign sel_h    = word_i[{byte_idx[OFF_W-1:1], 4'b0000} +: 16];

    always_comb begin
        if (misalign_i) begin
            data_o = '0;
        end else begin
            unique case (size_i)
                ACC_BYTE: data_o = {{(XLEN-8){signed_i & sel_b[7]}}, sel_b};
                ACC_HALF: data_o = {{(XLEN-16){signed_i & sel_h[15]}}, sel_h};
                default:  data_o = word_i;
            endcase
        end
    end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit #(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [1:0]                     acc_size_i,
    input  logic                           is_store_i,
    input  logic                           ld_signed_i,
    input  logic [XLEN-1:0]                st_data_i,
    input  logic [XLEN-1:0]                mem_rdata_i,
    output logic [ADDR_W-$clog2(XLEN/8)-1:0] word_addr_o,
    output logic [XLEN/8-1:0]              byte_en_o,
    output logic [XLEN-1:0]                wdata_o,
    output logic [XLEN-1:0]                ld_data_o,
    output logic                           misalign_o
);
    import lsa_pkg::*;
    localparam int NLANE = XLEN / 8;
    localparam int OFF_W = $clog2(NLANE);

    acc_size_e          size;
    logic [OFF_W-1:0]   off;
    logic               mis_c;
    logic [NLANE-1:0]   en_c;
    logic [XLEN-1:0]    wd_c;
    logic [XLEN-1:0]    ld_c;

    assign size = acc_size_e'(acc_size_i);
    assign off  = addr_i[OFF_W-1:0];

    lsa_align_check #(.OFF_W(OFF_W)) u_align (
        .size_i     (size),
        .off_i      (off),
        .misalign_o (mis_c)
    );

    lsa_store_lanes #(.XLEN(XLEN)) u_store (
        .size_i     (size),
        .off_i      (off),
        .store_i    (is_store_i),
        .misalign_i (mis_c),
        .src_i      (st_data_i),
        .en_o       (en_c),
        .data_o     (wd_c)
    );

    lsa_load_extract #(.XLEN(XLEN)) u_load (
        .size_i     (size),
        .off_i      (off),
        .signed_i   (ld_signed_i),
        .misalign_i (mis_c),
        .word_i     (mem_rdata_i),
        .data_o     (ld_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr_o <= '0;
            byte_en_o   <= '0;
            wdata_o     <= '0;
            ld_data_o   <= '0;
            misalign_o  <= 1'b0;
        end else begin
            word_addr_o <= addr_i[ADDR_W-1:OFF_W];
            byte_en_o   <= en_c;
            wdata_o     <= wd_c;
            ld_data_o   <= ld_c;
            misalign_o  <= mis_c;
        end
    end
endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              addr_i,
    input logic [1:0]                     acc_size_i,
    input logic                           is_store_i,
    input logic                           ld_signed_i,
    input logic [ADDR_W-$clog2(XLEN/8)-1:0] word_addr_o,
    input logic [XLEN/8-1:0]              byte_en_o,
    input logic [XLEN-1:0]                ld_data_o,
    input logic                           misalign_o
);
    localparam int OFF_W = $clog2(XLEN/8);

    p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> word_addr_o == $past(addr_i[ADDR_W-1:OFF_W]));

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store_i && acc_size_i == 2'b00) |=> $countones(byte_en_o) == 1);

    p_mis_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> byte_en_o == '0);

    p_half_odd_mis_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == 2'b01 && addr_i[0]) |=> misalign_o);

    p_load_no_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_store_i |=> byte_en_o == '0);

    p_ubyte_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_store_i && !ld_signed_i && acc_size_i == 2'b00) |=> ld_data_o[XLEN-1:8] == '0);

    p_alt_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store_i && acc_size_i == 2'b11 && addr_i[OFF_W-1:0] == '0) |=> byte_en_o == '1);
endmodule

bind lsa_unit lsa_unit_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_lsa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (addr_i),
    .acc_size_i  (acc_size_i),
    .is_store_i  (is_store_i),
    .ld_signed_i (ld_signed_i),
    .word_addr_o (word_addr_o),
    .byte_en_o   (byte_en_o),
    .ld_data_o   (ld_data_o),
    .misalign_o  (misalign_o)
);

// File: tb/test_lsa_unit.sv
`timescale 1ns/1ps
module test_lsa_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr_i = '0;
    logic [1:0]  acc_size_i = '0;
    logic        is_store_i = 1'b0;
    logic        ld_signed_i = 1'b0;
    logic [31:0] st_data_i = '0;
    logic [31:0] mem_rdata_i = '0;
    logic [29:0] word_addr_o;
    logic [3:0]  byte_en_o;
    logic [31:0] wdata_o;
    logic [31:0] ld_data_o;
    logic        misalign_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // expected values queued for the next sampling point
    bit          pend = 0;
    bit          e_store, e_sgn;
    int          e_sz;
    logic [29:0] e_wa;
    logic [3:0]  e_en;
    logic [31:0] e_wd, e_ld;
    logic        e_mis;

    always #2 clk = ~clk;

    lsa_unit i_lsa_unit (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .acc_size_i(acc_size_i),
        .is_store_i(is_store_i), .ld_signed_i(ld_signed_i), .st_data_i(st_data_i),
        .mem_rdata_i(mem_rdata_i), .word_addr_o(word_addr_o), .byte_en_o(byte_en_o),
        .wdata_o(wdata_o), .ld_data_o(ld_data_o), .misalign_o(misalign_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_pending();
        string r;
        if (!pend) return;
        chk("R2 word address", 32'(word_addr_o), 32'(e_wa));
        r = (e_sz == 3) ? "R11 misalign" : "R6 misalign";
        chk(r, 32'(misalign_o), 32'(e_mis));
        if (e_store) begin
            if (e_mis)             r = "R6 enables";
            else if (e_sz == 0)    r = "R3 enables";
            else if (e_sz == 1)    r = "R4 enables";
            else if (e_sz == 2)    r = "R5 enables";
            else                   r = "R11 enables";
            chk(r, 32'(byte_en_o), 32'(e_en));
            if (!e_mis) begin
                r = (e_sz == 0) ? "R3 wdata" : (e_sz == 1) ? "R4 wdata" :
                    (e_sz == 2) ? "R5 wdata" : "R11 wdata";
                chk(r, wdata_o, e_wd);
            end
        end else begin
            chk("R7 load enables", 32'(byte_en_o), 32'(e_en));
            if (e_mis)             r = "R6 load data";
            else if (e_sz == 3)    r = "R11 load data";
            else if (e_sz == 2)    r = "R10 load data";
            else if (e_sgn)        r = "R8 load data";
            else                   r = "R9 load data";
            chk(r, ld_data_o, e_ld);
        end
    endtask

    // behavioural reference for one access
    task automatic access(input logic [31:0] a, input int sz, input bit st,
                          input bit sg, input logic [31:0] d, input logic [31:0] m);
        int off, ez;
        logic [31:0] v;
        @(negedge clk);
        compare_pending();
        addr_i = a; acc_size_i = 2'(sz); is_store_i = st; ld_signed_i = sg;
        st_data_i = d; mem_rdata_i = m;
        off = int'(a[1:0]);
        ez  = (sz == 3) ? 2 : sz;
        e_store = st; e_sgn = sg; e_sz = sz;
        e_wa  = a[31:2];
        e_mis = (ez == 1 && a[0]) || (ez == 2 && off != 0);
        e_en  = 4'b0000;
        if (st && !e_mis) begin
            if (ez == 0)      e_en = 4'b1000 >> off;
            else if (ez == 1) e_en = (off == 0) ? 4'b1100 : 4'b0011;
            else              e_en = 4'b1111;
        end
        if (ez == 0)      e_wd = {d[7:0], d[7:0], d[7:0], d[7:0]};
        else if (ez == 1) e_wd = {d[15:0], d[15:0]};
        else              e_wd = d;
        if (e_mis) e_ld = 32'h0;
        else if (ez == 0) begin
            v = (m >> (8 * (3 - off))) & 32'hFF;
            e_ld = (sg && v[7]) ? (v | 32'hFFFF_FF00) : v;
        end else if (ez == 1) begin
            v = (m >> (16 * (1 - off / 2))) & 32'hFFFF;
            e_ld = (sg && v[15]) ? (v | 32'hFFFF_0000) : v;
        end else e_ld = m;
        pend = 1;
    endtask

    initial begin
        #20000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        addr_i = 32'hFFFF_FFFF; is_store_i = 1'b1; st_data_i = 32'hFFFF_FFFF;
        mem_rdata_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset
        chk("R1 word_addr", 32'(word_addr_o), 0);
        chk("R1 byte_en", 32'(byte_en_o), 0);
        chk("R1 wdata", wdata_o, 0);
        chk("R1 ld_data", ld_data_o, 0);
        chk("R1 misalign", 32'(misalign_o), 0);
        rst_n = 1'b1;

        // exhaustive offsets x size codes x direction x sign, two lane patterns
        for (int p = 0; p < 2; p++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int st = 0; st < 2; st++) begin
                        for (int sg = 0; sg < 2; sg++) begin
                            access({24'h00A5C3, 6'(sz * 4 + o + p), 2'(o)}, sz, st[0], sg[0],
                                   p ? 32'h1357_9BDF : 32'hCAFE_B480,
                                   p ? 32'h7F01_6E02 : 32'h80F1_C2A3);
                        end
                    end
                end
            end
        end
        // targeted corner values
        access(32'h0000_0003, 0, 0, 1, 0, 32'h0000_0080); // R8 byte 0x80 -> FFFFFF80
        access(32'h0000_0003, 0, 0, 0, 0, 32'h0000_0080); // R9 byte 0x80 -> 00000080
        access(32'h0000_0000, 1, 0, 1, 0, 32'h8001_7FFF); // R8 upper half
        access(32'h0000_0002, 1, 0, 1, 0, 32'h8001_7FFF); // R8 lower half positive
        access(32'h0000_0001, 2, 1, 0, 32'hFFFF_FFFF, 0); // R6 word misaligned store
        access(32'h0000_0003, 3, 1, 0, 32'hFFFF_FFFF, 0); // R11 misaligned alt word
        for (int k = 0; k < 200; k++) begin
            access($urandom, int'($urandom % 4), 1'($urandom), 1'($urandom),
                   $urandom, $urandom);
        end
        @(negedge clk);
        compare_pending();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule